// File: doc/BRIEF.md
# PHY Bring-Up and Link Mode Resolver

This block is a hardware sequencer that brings an external Ethernet PHY into service after a start pulse. It works entirely through MDIO register reads and writes. It finds the PHY, either by scanning all 32 management addresses or by taking a strapped address. It soft-resets the PHY and checks whether autonegotiation is enabled. If it is, the block waits for negotiation to finish, bounded by an overall cycle timeout. It then resolves the link mode from the local ability and link-partner ability registers: gigabit, 100 Mbit or 10 Mbit, and full or half duplex.

The block does not drive the MDIO pins. It hands single register transactions to a separate MDIO frame controller over a request/response port. A request is held until the controller accepts it. The controller then returns one response pulse, carrying read data for reads and no data for writes.

When the sequence ends, the mode bits, the selected PHY address and the done/fail flags are registered. They stay stable until the next accepted start pulse.

Top module: `phy_linkup_seq`

## Requirements
- R1: With `fixed_addr_en` low, addresses 0 up to 31 are read at register 0 in rising order. The first address whose value is neither 0x0000 nor 0xFFFF becomes `phy_addr`. If none qualifies, address 0 is used. With `fixed_addr_en` high, `fixed_addr` is used and no scan takes place.
- R2: Register 0 is read repeatedly while its bit 15 is set. Once bit 15 reads clear, register 0 is written exactly once with that value ORed with 0x8000. Register 0 is then polled again until bit 15 reads clear.
- R3: If register 0 bit 12 reads clear after the reset, register 0 is written with 0x0000. The sequence then ends with no failure and all mode outputs low, meaning 10 Mbit half duplex.
- R4: After autonegotiation completes (register 1 bit 5 set), gigabit is resolved only when register 1 bit 8 was set in that same read. Common 1000-full ability (register 9 bit 9 and register 10 bit 11) gives gigabit full duplex. Common 1000-half ability (register 9 bit 8 and register 10 bit 10) gives gigabit half duplex and overrides full duplex. `link_gbit` and `link_100` are never high together.
- R5: If gigabit was not resolved, or `mac_gbit` is low, registers 4 and 5 are compared and three rules are applied in this order. Both bit 8 set gives 100 Mbit full duplex. Both bit 7 set gives 100 Mbit half duplex. Both bit 6 set sets full duplex and leaves the speed as it is.
- R6: If gigabit was resolved but `mac_gbit` is low, gigabit and duplex are cleared after R5 is applied. Register 0 is then written with the resolved 100 Mbit bit placed at bit 13 and all other bits zero.
- R7: If register 1 bit 5 still reads clear once the timeout has expired, register 0 is read and the mode is taken from it. Gigabit is bit 6 set with bit 13 clear. 100 Mbit is bit 13 set with bit 6 clear. Duplex is bit 8. The sequence ends with no failure.
- R8: If a register 0 read during either reset poll shows bit 15 set after the timeout has expired, the sequence ends with `done` and `fail` high and all mode outputs low.
- R9: After reset all outputs are low. An accepted start clears `done`, `fail` and the mode outputs on the next cycle. Once `done` is high, the outputs hold until the next start.
- R10: A request holds `req_valid` and all request fields stable until `req_ready` is seen. Only one transaction is outstanding at a time, and no request is raised while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only while the sequencer is idle |
| fixed_addr_en | input | 1 | Use `fixed_addr` instead of scanning |
| fixed_addr | input | 5 | Strapped PHY address |
| mac_gbit | input | 1 | MAC supports gigabit operation |
| req_valid | output | 1 | MDIO transaction request |
| req_ready | input | 1 | Controller accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | 5 | PHY address of the transaction |
| req_reg | output | 5 | Register number of the transaction |
| req_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | One-cycle response of the accepted transaction |
| rsp_rdata | input | 16 | Read data, valid with `rsp_valid` |
| done | output | 1 | Sequence finished (success or failure) |
| fail | output | 1 | Sequence ended by a reset timeout |
| link_gbit | output | 1 | Gigabit mode resolved |
| link_100 | output | 1 | 100 Mbit mode resolved |
| link_fd | output | 1 | Full duplex resolved |
| phy_addr | output | 5 | PHY address in use |

## Verification
The assertions assume the MDIO controller returns exactly one `rsp_valid` pulse for each accepted request, never sends a response that was not asked for, and holds `mac_gbit` and the address straps steady during a sequence. The bench's PHY responder meets these assumptions by construction. It accepts a pending request after a random delay, answers once after a random latency of zero to two cycles, and changes the straps only between sequences, while the sequencer is idle. The register contents of each sequence are chosen at random or by direct case, and the expected mode is computed from R4 to R7.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int PHY_AW = 5;
    localparam int REG_AW = 5;
    localparam int MD_DW  = 16;
    localparam int N_ADDR = 1 << PHY_AW;

    // register numbers the sequence touches
    localparam logic [REG_AW-1:0] RN_CTRL  = 5'd0;
    localparam logic [REG_AW-1:0] RN_STAT  = 5'd1;
    localparam logic [REG_AW-1:0] RN_ABIL  = 5'd4;
    localparam logic [REG_AW-1:0] RN_PABIL = 5'd5;
    localparam logic [REG_AW-1:0] RN_GABIL = 5'd9;
    localparam logic [REG_AW-1:0] RN_GPAB  = 5'd10;

    // bit positions
    localparam int B_CTRL_RST  = 15;
    localparam int B_CTRL_SPD  = 13;
    localparam int B_CTRL_ANEN = 12;
    localparam int B_CTRL_DUP  = 8;
    localparam int B_CTRL_SPHI = 6;
    localparam int B_STAT_EXT  = 8;
    localparam int B_STAT_ANOK = 5;

    typedef enum logic [3:0] {
        S_IDLE, S_SCAN, S_RST_POLL, S_RST_WR, S_RST_WAIT, S_FORCE_WR,
        S_AN_POLL, S_TO_RD, S_RD_G, S_RD_GP, S_EXT_DEC, S_RD_A, S_RD_PA,
        S_BASE_DEC, S_DOWN_WR
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regn;
        logic [MD_DW-1:0]  wdata;
    } md_cmd_t;

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
    parameter int unsigned LIMIT = 375000000,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q >= CW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/phy_seq_xact.sv
module phy_seq_xact
    import phy_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  md_cmd_t           cmd,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [PHY_AW-1:0] req_phy,
    output logic [REG_AW-1:0] req_reg,
    output logic [MD_DW-1:0]  req_wdata,
    input  logic              rsp_valid,
    input  logic [MD_DW-1:0]  rsp_rdata,
    output logic              fin,
    output logic [MD_DW-1:0]  rdata
);

    typedef enum logic [1:0] { X_IDLE, X_REQ, X_WAIT } xst_e;

    typedef struct packed {
        xst_e    st;
        md_cmd_t cmd;
    } xreg_t;

    xreg_t x_d, x_q;

    assign req_valid = (x_q.st == X_REQ);
    assign req_write = x_q.cmd.wr;
    assign req_phy   = x_q.cmd.phy;
    assign req_reg   = x_q.cmd.regn;
    assign req_wdata = x_q.cmd.wdata;
    assign fin       = (x_q.st == X_WAIT) && rsp_valid;
    assign rdata     = rsp_rdata;

    always_comb begin
        x_d = x_q;
        case (x_q.st)
            X_IDLE: if (go) begin
                x_d.st  = X_REQ;
                x_d.cmd = cmd;
            end
            X_REQ:  if (req_ready) x_d.st = X_WAIT;
            X_WAIT: if (rsp_valid) x_d.st = X_IDLE;
            default: x_d.st = X_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) x_q <= '{st: X_IDLE, cmd: '0};
        else        x_q <= x_d;
    end

endmodule

// File: rtl/phy_seq_resolve.sv
module phy_seq_resolve (
    input  logic       has_ext,
    input  logic [1:0] gab,      // [1]=1000 full, [0]=1000 half (local)
    input  logic [1:0] gpab,     // [1]=1000 full, [0]=1000 half (partner)
    input  logic [2:0] ab,       // [2]=100 full, [1]=100 half, [0]=10 full (local)
    input  logic [2:0] pab,      // same layout (partner)
    input  logic       mac_gbit,
    input  logic       fb_sphi,
    input  logic       fb_spd,
    input  logic       fb_dup,
    output logic       ext_gb,
    output logic       base_needed,
    output logic       fin_gb,
    output logic       fin_sp,
    output logic       fin_fd,
    output logic       downgrade,
    output logic       fb_gb,
    output logic       fb_sp,
    output logic       fb_fd
);

    logic       ext_fd;
    logic [1:0] gcom;
    logic [2:0] bcom;

    assign gcom = has_ext ? (gab & gpab) : 2'b00;
    assign bcom = ab & pab;

    always_comb begin
        ext_gb = 1'b0;
        ext_fd = 1'b0;
        if (gcom[1]) begin
            ext_gb = 1'b1;
            ext_fd = 1'b1;
        end
        if (gcom[0]) begin
            ext_gb = 1'b1;
            ext_fd = 1'b0;
        end
    end

    assign base_needed = !ext_gb || !mac_gbit;
    assign downgrade   = ext_gb && !mac_gbit;

    always_comb begin
        fin_gb = ext_gb;
        fin_sp = 1'b0;
        fin_fd = ext_fd;
        if (base_needed) begin
            if (bcom[2]) begin
                fin_sp = 1'b1;
                fin_fd = 1'b1;
            end
            if (bcom[1]) begin
                fin_sp = 1'b1;
                fin_fd = 1'b0;
            end
            if (bcom[0]) fin_fd = 1'b1;
            if (downgrade) begin
                fin_gb = 1'b0;
                fin_fd = 1'b0;
            end
        end
    end

    assign fb_gb = fb_sphi && !fb_spd;
    assign fb_sp = !fb_sphi && fb_spd;
    assign fb_fd = fb_dup;

endmodule

// File: rtl/phy_linkup_seq.sv
module phy_linkup_seq
    import phy_seq_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 375000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fixed_addr_en,
    input  logic [PHY_AW-1:0] fixed_addr,
    input  logic              mac_gbit,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [PHY_AW-1:0] req_phy,
    output logic [REG_AW-1:0] req_reg,
    output logic [MD_DW-1:0]  req_wdata,
    input  logic              rsp_valid,
    input  logic [MD_DW-1:0]  rsp_rdata,
    output logic              done,
    output logic              fail,
    output logic              link_gbit,
    output logic              link_100,
    output logic              link_fd,
    output logic [PHY_AW-1:0] phy_addr
);

    localparam logic [PHY_AW-1:0] LAST_ADDR = PHY_AW'(N_ADDR - 1);
    localparam logic [MD_DW-1:0]  ALL_ONES  = '1;

    typedef struct packed {
        seq_state_e        state;
        logic              issued;
        logic [PHY_AW-1:0] addr;
        logic [MD_DW-1:0]  tmp;
        logic              has_ext;
        logic [1:0]        gab;
        logic [1:0]        gpab;
        logic [2:0]        ab;
        logic [2:0]        pab;
        logic              gb;
        logic              sp;
        logic              fd;
        logic              done;
        logic              fail;
    } seq_t;

    seq_t s_d, s_q;

    md_cmd_t          cmd;
    logic             is_x, x_go, x_fin;
    logic [MD_DW-1:0] x_rdata;
    logic             seq_idle, tmr_clear, tmr_exp;
    logic             r_ext_gb, r_base, r_gb, r_sp, r_fd, r_down;
    logic             r_fbgb, r_fbsp, r_fbfd;

    assign seq_idle  = (s_q.state == S_IDLE);
    assign tmr_clear = seq_idle && start;

    phy_seq_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .run(!seq_idle),
        .expired(tmr_exp)
    );

    phy_seq_xact i_xact (
        .clk(clk), .rst_n(rst_n), .go(x_go), .cmd(cmd),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .fin(x_fin), .rdata(x_rdata)
    );

    phy_seq_resolve i_resolve (
        .has_ext(s_q.has_ext), .gab(s_q.gab), .gpab(s_q.gpab),
        .ab(s_q.ab), .pab(s_q.pab), .mac_gbit(mac_gbit),
        .fb_sphi(x_rdata[B_CTRL_SPHI]), .fb_spd(x_rdata[B_CTRL_SPD]),
        .fb_dup(x_rdata[B_CTRL_DUP]),
        .ext_gb(r_ext_gb), .base_needed(r_base), .fin_gb(r_gb),
        .fin_sp(r_sp), .fin_fd(r_fd), .downgrade(r_down),
        .fb_gb(r_fbgb), .fb_sp(r_fbsp), .fb_fd(r_fbfd)
    );

    // command for the transaction owned by the current state
    always_comb begin
        cmd      = '0;
        cmd.phy  = s_q.addr;
        is_x     = 1'b1;
        case (s_q.state)
            S_SCAN, S_RST_POLL, S_RST_WAIT, S_TO_RD: cmd.regn = RN_CTRL;
            S_RST_WR: begin
                cmd.wr    = 1'b1;
                cmd.regn  = RN_CTRL;
                cmd.wdata = s_q.tmp | (MD_DW'(1) << B_CTRL_RST);
            end
            S_FORCE_WR: begin
                cmd.wr   = 1'b1;
                cmd.regn = RN_CTRL;
            end
            S_DOWN_WR: begin
                cmd.wr    = 1'b1;
                cmd.regn  = RN_CTRL;
                cmd.wdata = MD_DW'(s_q.sp) << B_CTRL_SPD;
            end
            S_AN_POLL: cmd.regn = RN_STAT;
            S_RD_G:    cmd.regn = RN_GABIL;
            S_RD_GP:   cmd.regn = RN_GPAB;
            S_RD_A:    cmd.regn = RN_ABIL;
            S_RD_PA:   cmd.regn = RN_PABIL;
            default:   is_x = 1'b0;
        endcase
    end

    assign x_go = is_x && !s_q.issued;

    always_comb begin
        s_d = s_q;
        if (x_go)  s_d.issued = 1'b1;
        if (x_fin) s_d.issued = 1'b0;

        case (s_q.state)
            S_IDLE: if (start) begin
                s_d.done    = 1'b0;
                s_d.fail    = 1'b0;
                s_d.gb      = 1'b0;
                s_d.sp      = 1'b0;
                s_d.fd      = 1'b0;
                s_d.has_ext = 1'b0;
                s_d.gab     = '0;
                s_d.gpab    = '0;
                s_d.ab      = '0;
                s_d.pab     = '0;
                s_d.issued  = 1'b0;
                if (fixed_addr_en) begin
                    s_d.addr  = fixed_addr;
                    s_d.state = S_RST_POLL;
                end else begin
                    s_d.addr  = '0;
                    s_d.state = S_SCAN;
                end
            end
            S_SCAN: if (x_fin) begin
                if (x_rdata != '0 && x_rdata != ALL_ONES) begin
                    s_d.state = S_RST_POLL;
                end else if (s_q.addr == LAST_ADDR) begin
                    s_d.addr  = '0;
                    s_d.state = S_RST_POLL;
                end else begin
                    s_d.addr = s_q.addr + 1'b1;
                end
            end
            S_RST_POLL, S_RST_WAIT: if (x_fin) begin
                if (x_rdata[B_CTRL_RST]) begin
                    if (tmr_exp) begin
                        s_d.fail  = 1'b1;
                        s_d.done  = 1'b1;
                        s_d.state = S_IDLE;
                    end
                end else begin
                    s_d.tmp = x_rdata;
                    if (s_q.state == S_RST_POLL) s_d.state = S_RST_WR;
                    else if (!x_rdata[B_CTRL_ANEN]) s_d.state = S_FORCE_WR;
                    else s_d.state = S_AN_POLL;
                end
            end
            S_RST_WR: if (x_fin) s_d.state = S_RST_WAIT;
            S_FORCE_WR: if (x_fin) begin
                s_d.done  = 1'b1;
                s_d.state = S_IDLE;
            end
            S_AN_POLL: if (x_fin) begin
                if (x_rdata[B_STAT_ANOK]) begin
                    s_d.has_ext = x_rdata[B_STAT_EXT];
                    s_d.state   = x_rdata[B_STAT_EXT] ? S_RD_G : S_RD_A;
                end else if (tmr_exp) begin
                    s_d.state = S_TO_RD;
                end
            end
            S_TO_RD: if (x_fin) begin
                s_d.gb    = r_fbgb;
                s_d.sp    = r_fbsp;
                s_d.fd    = r_fbfd;
                s_d.done  = 1'b1;
                s_d.state = S_IDLE;
            end
            S_RD_G: if (x_fin) begin
                s_d.gab   = x_rdata[9:8];
                s_d.state = S_RD_GP;
            end
            S_RD_GP: if (x_fin) begin
                s_d.gpab  = x_rdata[11:10];
                s_d.state = S_EXT_DEC;
            end
            S_EXT_DEC: begin
                if (r_base) begin
                    s_d.state = S_RD_A;
                end else begin
                    s_d.gb    = r_ext_gb;
                    s_d.sp    = r_sp;
                    s_d.fd    = r_fd;
                    s_d.done  = 1'b1;
                    s_d.state = S_IDLE;
                end
            end
            S_RD_A: if (x_fin) begin
                s_d.ab    = x_rdata[8:6];
                s_d.state = S_RD_PA;
            end
            S_RD_PA: if (x_fin) begin
                s_d.pab   = x_rdata[8:6];
                s_d.state = S_BASE_DEC;
            end
            S_BASE_DEC: begin
                s_d.gb = r_gb;
                s_d.sp = r_sp;
                s_d.fd = r_fd;
                if (r_down) begin
                    s_d.state = S_DOWN_WR;
                end else begin
                    s_d.done  = 1'b1;
                    s_d.state = S_IDLE;
                end
            end
            S_DOWN_WR: if (x_fin) begin
                s_d.done  = 1'b1;
                s_d.state = S_IDLE;
            end
            default: s_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: S_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign done      = s_q.done;
    assign fail      = s_q.fail;
    assign link_gbit = s_q.gb;
    assign link_100  = s_q.sp;
    assign link_fd   = s_q.fd;
    assign phy_addr  = s_q.addr;

endmodule

// File: rtl/phy_linkup_chk.sv
module phy_linkup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        seq_idle,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [4:0]  req_phy,
    input logic [4:0]  req_reg,
    input logic [15:0] req_wdata,
    input logic        done,
    input logic        fail,
    input logic        link_gbit,
    input logic        link_100,
    input logic        link_fd
);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_write) &&
        $stable(req_phy) && $stable(req_reg) && $stable(req_wdata));

    p_no_req_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

    p_fail_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    p_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !link_gbit && !link_100 && !link_fd);

    p_speed_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        link_gbit |-> !link_100);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(fail) && $stable(link_gbit) &&
        $stable(link_100) && $stable(link_fd));

    p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start && seq_idle |=> !done && !fail && !link_gbit && !link_100 && !link_fd);

endmodule

bind phy_linkup_seq phy_linkup_chk i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .seq_idle(seq_idle),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .done(done), .fail(fail), .link_gbit(link_gbit), .link_100(link_100),
    .link_fd(link_fd)
);

// File: tb/test_phy_linkup_seq.sv
module test_phy_linkup_seq;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, start, fixed_addr_en, mac_gbit;
    logic [4:0]  fixed_addr;
    logic        req_valid, req_ready, req_write, rsp_valid;
    logic [4:0]  req_phy, req_reg, phy_addr;
    logic [15:0] req_wdata, rsp_rdata;
    logic        done, fail, link_gbit, link_100, link_fd;

    phy_linkup_seq #(.TIMEOUT_CYC(3000)) i_phy_linkup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .fixed_addr_en(fixed_addr_en),
        .fixed_addr(fixed_addr), .mac_gbit(mac_gbit),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .done(done), .fail(fail), .link_gbit(link_gbit), .link_100(link_100),
        .link_fd(link_fd), .phy_addr(phy_addr)
    );

    int n_chk = 0;
    int n_bad = 0;

    // PHY model
    int          m_addr, m_addr2, m_rst_cnt, m_rst_after, m_an_cnt;
    logic [15:0] m_other, m_r0, m_r1, m_r4, m_r5, m_r9, m_r10;
    logic [15:0] first_wr0, last_wr0;
    int          wr0_cnt;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input int phy, input int rg);
        logic [15:0] v;
        v = 16'h0000;
        if (phy == m_addr) begin
            case (rg)
                0: begin
                    v = m_r0;
                    if (m_rst_cnt > 0) begin
                        m_rst_cnt--;
                        v = m_r0 | 16'h8000;
                    end
                end
                1: begin
                    if (m_an_cnt > 0) begin
                        m_an_cnt--;
                        v = m_r1 & 16'hFFDF;
                    end else v = m_r1 | 16'h0020;
                end
                4: v = m_r4;
                5: v = m_r5;
                9: v = m_r9;
                10: v = m_r10;
                default: v = 16'h0000;
            endcase
        end else if (phy == m_addr2) begin
            v = (rg == 0) ? 16'h1000 : 16'h0000;
        end else begin
            v = m_other;
        end
        return v;
    endfunction

    initial begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_rdata = 16'h0000;
        forever begin
            @(negedge clk);
            if (req_valid && ($urandom % 2 == 1)) begin
                logic        w;
                int          p, r, lat;
                logic [15:0] wd;
                w = req_write; p = int'(req_phy); r = int'(req_reg); wd = req_wdata;
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                lat = $urandom % 3;
                repeat (lat) @(negedge clk);
                if (w) begin
                    rsp_rdata = 16'h0000;
                    if (r == 0) begin
                        if (wr0_cnt == 0) first_wr0 = wd;
                        last_wr0 = wd;
                        wr0_cnt++;
                        if (p == m_addr) begin
                            m_r0 = wd & 16'h7FFF;
                            if (wd[15]) m_rst_cnt = m_rst_after;
                        end
                    end
                end else begin
                    rsp_rdata = model_read(p, r);
                end
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    // expected mode from R4..R6: {downgrade, gb, sp, fd}
    function automatic logic [3:0] exp_mode(input logic [15:0] r1, r4, r5, r9, r10,
                                            input logic mac);
        logic gb, sp, fd, dg;
        gb = 0; sp = 0; fd = 0; dg = 0;
        if (r1[8]) begin
            if (r9[9] && r10[11]) begin gb = 1; fd = 1; end
            if (r9[8] && r10[10]) begin gb = 1; fd = 0; end
        end
        if (!gb || !mac) begin
            if (r4[8] && r5[8]) begin sp = 1; fd = 1; end
            if (r4[7] && r5[7]) begin sp = 1; fd = 0; end
            if (r4[6] && r5[6]) fd = 1;
            if (gb && !mac) begin gb = 0; fd = 0; dg = 1; end
        end
        return {dg, gb, sp, fd};
    endfunction

    task automatic setup(input int addr, input int addr2, input logic [15:0] other,
                         input logic [15:0] r0, input int rst0, input int rsta,
                         input int an, input logic [15:0] r1,
                         input logic [15:0] r4, input logic [15:0] r5,
                         input logic [15:0] r9, input logic [15:0] r10);
        m_addr = addr; m_addr2 = addr2; m_other = other; m_r0 = r0;
        m_rst_cnt = rst0; m_rst_after = rsta; m_an_cnt = an; m_r1 = r1;
        m_r4 = r4; m_r5 = r5; m_r9 = r9; m_r10 = r10;
        wr0_cnt = 0; first_wr0 = 16'hDEAD; last_wr0 = 16'hDEAD;
    endtask

    task automatic run(input logic fen, input logic [4:0] fa, input logic mac);
        int guard;
        @(negedge clk);
        fixed_addr_en = fen; fixed_addr = fa; mac_gbit = mac;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 done cleared after start", {31'd0, done}, 32'd0);
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk("R9 sequence reached done", {31'd0, done}, 32'd1);
    endtask

    task automatic chk_mode(input string tag, input logic f, input logic gb,
                            input logic sp, input logic fd);
        chk(tag, {28'd0, fail, link_gbit, link_100, link_fd}, {28'd0, f, gb, sp, fd});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog act=hung exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] e;
        logic [15:0] hold;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; start = 1'b0; fixed_addr_en = 1'b0; fixed_addr = '0; mac_gbit = 1'b1;
        setup(40, -1, 16'h0000, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (5) @(negedge clk);
        chk("R9 reset outputs", {26'd0, done, fail, link_gbit, link_100, link_fd, req_valid},
            32'd0);
        chk("R9 reset phy_addr", {27'd0, phy_addr}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 fixed address, R2 reset write, R4 gigabit full
        setup(3, -1, 16'hFFFF, 16'h1140, 2, 3, 3, 16'h0100, 16'h01E0, 16'h01E0,
              16'h0200, 16'h0800);
        run(1'b1, 5'd3, 1'b1);
        chk("R1 fixed address", {27'd0, phy_addr}, 32'd3);
        chk("R2 reset write value", {16'd0, first_wr0}, 32'h9140);
        chk("R2 single reset write", wr0_cnt, 32'd1);
        chk_mode("R4 gigabit full", 0, 1, 0, 1);

        // R1 scan picks first, R4 half overrides full
        setup(7, 12, 16'hFFFF, 16'h1100, 0, 1, 1, 16'h0100, 16'h0000, 16'h0000,
              16'h0300, 16'h0C00);
        run(1'b0, 5'd0, 1'b1);
        chk("R1 scan first address", {27'd0, phy_addr}, 32'd7);
        chk_mode("R4 gigabit half wins", 0, 1, 0, 0);

        // R1 no PHY found -> address 0, R3 forced mode
        setup(40, -1, 16'h0000, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0);
        run(1'b0, 5'd9, 1'b1);
        chk("R1 default address 0", {27'd0, phy_addr}, 32'd0);
        chk_mode("R3 forced 10 half", 0, 0, 0, 0);
        chk("R3 forced write zero", {16'd0, last_wr0}, 32'h0000);

        // R3 autoneg disabled on a found PHY
        setup(2, -1, 16'h0000, 16'h0100, 1, 1, 0, 16'h0100, 16'h01C0, 16'h01C0, 0, 0);
        run(1'b0, 5'd0, 1'b1);
        chk("R1 scan address 2", {27'd0, phy_addr}, 32'd2);
        chk_mode("R3 no autoneg", 0, 0, 0, 0);
        chk("R3 write zero", {16'd0, last_wr0}, 32'h0000);
        chk("R3 write count", wr0_cnt, 32'd2);

        // R6 downgrade with 100 full
        setup(4, -1, 16'hFFFF, 16'h1000, 0, 1, 2, 16'h0100, 16'h0100, 16'h0100,
              16'h0200, 16'h0800);
        run(1'b1, 5'd4, 1'b0);
        chk_mode("R6 downgrade 100", 0, 0, 1, 0);
        chk("R6 downgrade write", {16'd0, last_wr0}, 32'h2000);

        // R6 downgrade with only 10 full common
        setup(4, -1, 16'hFFFF, 16'h1000, 0, 1, 0, 16'h0100, 16'h0040, 16'h0040,
              16'h0100, 16'h0400);
        run(1'b1, 5'd4, 1'b0);
        chk_mode("R6 downgrade 10", 0, 0, 0, 0);
        chk("R6 downgrade write 10", {16'd0, last_wr0}, 32'h0000);
        chk("R6 write count", wr0_cnt, 32'd2);

        // R5 ordered rules: 100 half and 10 full both common
        setup(6, -1, 16'hFFFF, 16'h1000, 0, 0, 0, 16'h0000, 16'h00C0, 16'h00C0, 0, 0);
        run(1'b1, 5'd6, 1'b1);
        chk_mode("R5 100 half then 10 full", 0, 0, 1, 1);

        // R4/R5 random mix
        for (int i = 0; i < 24; i++) begin
            logic [15:0] r1, r4, r5, r9, r10;
            logic mac;
            int a;
            a = $urandom % 32;
            r1 = ($urandom % 2) ? 16'h0100 : 16'h0000;
            r4 = 16'($urandom); r5 = 16'($urandom);
            r9 = 16'($urandom); r10 = 16'($urandom);
            mac = 1'($urandom % 2);
            setup(a, -1, 16'hFFFF, 16'h1000 | (16'($urandom) & 16'h6FFF),
                  $urandom % 3, $urandom % 3, $urandom % 4, r1, r4, r5, r9, r10);
            run(1'b1, 5'(a), mac);
            e = exp_mode(r1, r4, r5, r9, r10, mac);
            chk_mode("R5 random resolution", 0, e[2], e[1], e[0]);
            if (e[3]) chk("R6 random downgrade write", {16'd0, last_wr0},
                          {16'd0, 2'b00, e[1], 13'd0});
        end

        // R7 autoneg timeout fallback
        setup(1, -1, 16'hFFFF, 16'h1140, 0, 0, 1000000, 16'h0100, 0, 0, 0, 0);
        run(1'b1, 5'd1, 1'b1);
        chk_mode("R7 fallback gigabit full", 0, 1, 0, 1);
        setup(1, -1, 16'hFFFF, 16'h3000, 0, 0, 1000000, 16'h0100, 0, 0, 0, 0);
        run(1'b1, 5'd1, 1'b1);
        chk_mode("R7 fallback 100 half", 0, 0, 1, 0);
        setup(1, -1, 16'hFFFF, 16'h3140, 0, 0, 1000000, 16'h0100, 0, 0, 0, 0);
        run(1'b1, 5'd1, 1'b0);
        chk_mode("R7 fallback both speed bits", 0, 0, 0, 1);

        // R8 reset never clears, before and after the write
        setup(1, -1, 16'hFFFF, 16'h1000, 1000000, 0, 0, 0, 0, 0, 0, 0);
        run(1'b1, 5'd1, 1'b1);
        chk_mode("R8 first poll timeout", 1, 0, 0, 0);
        chk("R8 no reset write", wr0_cnt, 32'd0);
        setup(1, -1, 16'hFFFF, 16'h1140, 0, 1000000, 0, 0, 0, 0, 0, 0);
        run(1'b1, 5'd1, 1'b1);
        chk_mode("R8 second poll timeout", 1, 0, 0, 0);

        // R9 hold after done, R10 no request while done
        setup(3, -1, 16'hFFFF, 16'h1000, 0, 0, 0, 16'h0000, 16'h0100, 16'h0100, 0, 0);
        run(1'b1, 5'd3, 1'b1);
        chk_mode("R5 100 full", 0, 0, 1, 1);
        hold = {10'd0, done, fail, link_gbit, link_100, link_fd, 1'b0};
        repeat (40) @(negedge clk);
        chk("R9 outputs held", {16'd0, 10'd0, done, fail, link_gbit, link_100, link_fd,
            1'b0}, {16'd0, hold});
        chk("R10 no request while done", {31'd0, req_valid}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule